// File: doc/BRIEF.md
# Compare Match Timer

A small bank of register-programmed timer channels. Each channel owns an up-counter, a compare register and a control/status register. One shared run register holds a start bit for every channel. A channel counts only while its run bit is set. Its count rate comes from the strobe input `ref_tick`, which marks each edge of the slow reference clock. A per-channel prescaler divides that strobe by 1, 8, 32 or 128.

In periodic mode the counter returns to zero on the tick after it equals the compare value. It also sets a match flag, so each period lasts compare + 1 ticks. In free-running mode a match only sets the flag and counting goes on. If the counter passes all ones without a match, it rolls over to zero and an overflow flag is set. Software clears the flags by writing zero to their bits. An interrupt line per channel follows the match flag when the interrupt is enabled and routed to the interrupt path.

A value written to the counter is staged. It reaches the counter, and becomes readable, only after two further reference strobes, so software polls the counter until the written value appears.

Top module: `cmt_timer`

## Requirements
- R1: Word addresses: 0 is the run register, with bit k the run bit of channel k. Channel k occupies words 4(k+1)+0 (control/status), +1 (counter) and +2 (compare). A read returns data on the clock edge after `rd_en`. Any other address reads as zero.
- R2: After reset the run register, control word and counter are zero, the compare register is all ones and `irq` is zero.
- R3: A channel's counter changes only while its own run bit is 1; other channels' run bits have no effect on it.
- R4: Control bits 2:0 select the divisor of `ref_tick`: 7 gives 1, 5 gives 32, 6 gives 128, and every other code (0 to 4) gives 8.
- R5: The prescaler restarts from zero each time the run bit goes from 0 to 1, so N strobes after a start give exactly floor(N / divisor) count ticks.
- R6: With control bit 8 set (periodic), a tick at counter == compare loads zero and sets the match flag (bit 15); after K ticks from zero the count is K mod (compare + 1).
- R7: With control bit 8 clear, a tick at counter == compare sets the match flag and the counter still increments.
- R8: A tick at all ones while compare is not all ones rolls the counter to zero and sets the overflow flag (bit 14); the match flag is not set by it.
- R9: A control write clears a flag only where the written bit is 0; writing 1 leaves it as it was. A flag set by a tick in the same cycle as a clearing write stays set.
- R10: `irq[k]` is 1 one cycle after the match flag is 1 with enable bit 7 set and routing field bits 5:4 equal to 2. Routing 0 (none) or 1 (DMA) keeps it at 0. It falls when the flag is cleared.
- R11: A counter write reaches the counter, and reads, on the second `ref_tick` strobe after the write; until then reads return the previous count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle strobe per reference count-clock edge |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | NUM_CH | Level interrupt request per channel |

## Verification
The bench builds the block with two channels, an 8-bit counter and a 5-bit word address. With the narrow counter, a full rollover from any start value takes at most 256 strobes, so the overflow path and free-running wraparound can be run to the end. All eight clock-select codes are swept with a stop/start between them. Compare values 0 to 15 are each run for every tick count up to two periods plus two, and the count, the match flag and the interrupt are predicted by modulo arithmetic.

// File: rtl/cmt_pkg.sv
`timescale 1ns/1ps
package cmt_pkg;
  localparam int DW      = 32;
  localparam int PRE_W   = 7;
  localparam int CMF_BIT = 15;
  localparam int OVF_BIT = 14;
  localparam int PER_BIT = 8;
  localparam int IE_BIT  = 7;
  localparam int RT_LO   = 4;
  localparam int SEL_LO  = 0;

  localparam logic [1:0] OFF_CTRL = 2'd0;
  localparam logic [1:0] OFF_CNT  = 2'd1;
  localparam logic [1:0] OFF_CMP  = 2'd2;

  typedef enum logic [1:0] {
    RT_NONE = 2'd0,
    RT_DMA  = 2'd1,
    RT_IRQ  = 2'd2,
    RT_RSVD = 2'd3
  } route_e;

  // Mask of low prescaler bits that must all be 1 for a tick.
  function automatic logic [PRE_W-1:0] div_mask(input logic [2:0] sel);
    logic [PRE_W-1:0] m;
    case (sel)
      3'd5:    m = PRE_W'(31);
      3'd6:    m = PRE_W'(127);
      3'd7:    m = PRE_W'(0);
      default: m = PRE_W'(7);
    endcase
    return m;
  endfunction
endpackage

// File: rtl/cmt_prescaler.sv
`timescale 1ns/1ps
module cmt_prescaler
  import cmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run_i,
  input  logic       ref_tick_i,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] phase_q;
  logic [PRE_W-1:0] mask;

  assign mask = div_mask(sel_i);

  // Phase is held at zero while stopped, so every start begins a fresh divide.
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (!run_i) begin
      phase_q <= '0;
    end else if (ref_tick_i) begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign tick_o = run_i && ref_tick_i && ((phase_q & mask) == mask);

  a_r5_phase_restart: assert property (@(posedge clk) disable iff (rst)
    $rose(run_i) |-> (phase_q == '0));
endmodule

// File: rtl/cmt_count_core.sv
`timescale 1ns/1ps
module cmt_count_core #(
  parameter int CNT_W = 32,
  parameter int LAT   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_tick_i,
  input  logic             cnt_tick_i,
  input  logic             periodic_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] wval_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             flag_wr_i,
  input  logic             keep_cmf_i,
  input  logic             keep_ovf_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             cmf_o,
  output logic             ovf_o
);
  localparam int LW = $clog2(LAT + 1);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [CNT_W-1:0] pend_q;
  logic [LW-1:0]    left_q;
  logic             cmf_q, ovf_q;
  logic             load_now, hit_cmp, hit_top;

  // Staged counter write: lands on the LAT-th reference strobe.
  assign load_now = ref_tick_i && (left_q == LW'(1)) && !cnt_wr_i;
  assign hit_cmp  = cnt_tick_i && !load_now && (cnt_q == cmp_i);
  assign hit_top  = cnt_tick_i && !load_now && (cnt_q == '1) && (cnt_q != cmp_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      left_q <= '0;
    end else if (cnt_wr_i) begin
      pend_q <= wval_i;
      left_q <= LW'(LAT);
    end else if (ref_tick_i && (left_q != '0)) begin
      left_q <= left_q - 1'b1;
    end
  end

  always_comb begin
    cnt_nxt = cnt_q;
    if (load_now) begin
      cnt_nxt = pend_q;
    end else if (cnt_tick_i) begin
      if (hit_cmp && periodic_i) cnt_nxt = '0;
      else                       cnt_nxt = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      cmf_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      // A hardware event wins over a clearing write in the same cycle.
      cmf_q <= hit_cmp | (cmf_q & (!flag_wr_i | keep_cmf_i));
      ovf_q <= hit_top | (ovf_q & (!flag_wr_i | keep_ovf_i));
    end
  end

  assign cnt_o = cnt_q;
  assign cmf_o = cmf_q;
  assign ovf_o = ovf_q;

  a_r6_periodic_wrap: assert property (@(posedge clk) disable iff (rst)
    (cnt_tick_i && !load_now && periodic_i && (cnt_q == cmp_i))
      |=> ((cnt_q == '0) && cmf_o));

  a_r7_free_continue: assert property (@(posedge clk) disable iff (rst)
    (cnt_tick_i && !load_now && !periodic_i && (cnt_q == cmp_i) && (cnt_q != '1))
      |=> ((cnt_q == CNT_W'($past(cnt_q) + 1'b1)) && cmf_o));

  a_r8_rollover: assert property (@(posedge clk) disable iff (rst)
    (cnt_tick_i && !load_now && (cnt_q == '1) && (cmp_i != '1))
      |=> ((cnt_q == '0) && ovf_o));

  a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!cnt_tick_i && !load_now) |=> $stable(cnt_q));

  a_r11_no_early_load: assert property (@(posedge clk) disable iff (rst)
    cnt_wr_i |=> !load_now);

  a_r9_flag_source: assert property (@(posedge clk) disable iff (rst)
    $rose(cmf_q) |-> $past(cnt_tick_i));
endmodule

// File: rtl/cmt_channel.sv
`timescale 1ns/1ps
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_i,
  input  logic          ref_tick_i,
  input  logic          wr_ctrl_i,
  input  logic          wr_cnt_i,
  input  logic          wr_cmp_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [1:0]    rd_off_i,
  output logic [DW-1:0] rd_word_o,
  output logic          irq_o
);
  logic             per_q, ie_q;
  route_e           route_q;
  logic [2:0]       sel_q;
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] cnt;
  logic             cmf, ovf, tick, irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q   <= 1'b0;
      ie_q    <= 1'b0;
      route_q <= RT_NONE;
      sel_q   <= 3'd0;
    end else if (wr_ctrl_i) begin
      per_q   <= wdata_i[PER_BIT];
      ie_q    <= wdata_i[IE_BIT];
      route_q <= route_e'(wdata_i[RT_LO +: 2]);
      sel_q   <= wdata_i[SEL_LO +: 3];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           cmp_q <= '1;
    else if (wr_cmp_i) cmp_q <= wdata_i[CNT_W-1:0];
  end

  cmt_prescaler u_presc (
    .clk        (clk),
    .rst        (rst),
    .run_i      (run_i),
    .ref_tick_i (ref_tick_i),
    .sel_i      (sel_q),
    .tick_o     (tick)
  );

  cmt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst        (rst),
    .ref_tick_i (ref_tick_i),
    .cnt_tick_i (tick),
    .periodic_i (per_q),
    .cnt_wr_i   (wr_cnt_i),
    .wval_i     (wdata_i[CNT_W-1:0]),
    .cmp_i      (cmp_q),
    .flag_wr_i  (wr_ctrl_i),
    .keep_cmf_i (wdata_i[CMF_BIT]),
    .keep_ovf_i (wdata_i[OVF_BIT]),
    .cnt_o      (cnt),
    .cmf_o      (cmf),
    .ovf_o      (ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= cmf && ie_q && (route_q == RT_IRQ);
  end
  assign irq_o = irq_q;

  always_comb begin
    rd_word_o = '0;
    case (rd_off_i)
      OFF_CTRL: begin
        rd_word_o[CMF_BIT]       = cmf;
        rd_word_o[OVF_BIT]       = ovf;
        rd_word_o[PER_BIT]       = per_q;
        rd_word_o[IE_BIT]        = ie_q;
        rd_word_o[RT_LO +: 2]    = route_q;
        rd_word_o[SEL_LO +: 3]   = sel_q;
      end
      OFF_CNT: rd_word_o = DW'(cnt);
      OFF_CMP: rd_word_o = DW'(cmp_q);
      default: rd_word_o = '0;
    endcase
  end

  a_r10_irq_cause: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(cmf));

  a_r10_route_block: assert property (@(posedge clk) disable iff (rst)
    ((route_q != RT_IRQ) && $stable(route_q)) |-> !irq_o);
endmodule

// File: rtl/cmt_timer.sv
`timescale 1ns/1ps
module cmt_timer
  import cmt_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam int GRP_W = ADDR_W - 2;

  logic [NUM_CH-1:0] run_q;
  logic [NUM_CH-1:0] hit;
  logic [DW-1:0]     ch_word [NUM_CH];
  logic [GRP_W-1:0]  grp;
  logic [1:0]        off;
  logic              run_sel;
  logic [DW-1:0]     rd_nxt, rdata_q;

  assign grp     = addr[ADDR_W-1:2];
  assign off     = addr[1:0];
  assign run_sel = (addr == '0);

  always_ff @(posedge clk) begin
    if (rst)                  run_q <= '0;
    else if (wr_en && run_sel) run_q <= wdata[NUM_CH-1:0];
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign hit[g] = (grp == GRP_W'(g + 1)) && (off != 2'd3);

    cmt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk        (clk),
      .rst        (rst),
      .run_i      (run_q[g]),
      .ref_tick_i (ref_tick),
      .wr_ctrl_i  (wr_en && hit[g] && (off == OFF_CTRL)),
      .wr_cnt_i   (wr_en && hit[g] && (off == OFF_CNT)),
      .wr_cmp_i   (wr_en && hit[g] && (off == OFF_CMP)),
      .wdata_i    (wdata),
      .rd_off_i   (off),
      .rd_word_o  (ch_word[g]),
      .irq_o      (irq[g])
    );
  end

  always_comb begin
    rd_nxt = '0;
    if (run_sel) rd_nxt = DW'(run_q);
    for (int i = 0; i < NUM_CH; i++) begin
      if (hit[i]) rd_nxt = ch_word[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_nxt;
  end
  assign rdata = rdata_q;

  a_r1_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !run_sel && (hit == '0)) |=> (rdata == '0));

  a_r3_run_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && run_sel) |=> (run_q == $past(wdata[NUM_CH-1:0])));
endmodule

// File: tb/cmt_timer_tb_top.sv
`timescale 1ns/1ps
module cmt_timer_tb_top;
  localparam int NCH = 2;
  localparam int CW  = 8;
  localparam int AW  = 5;
  localparam logic [31:0] PER  = 32'h100;
  localparam logic [31:0] IE   = 32'h080;
  localparam logic [31:0] RIRQ = 32'h020;
  localparam logic [31:0] RDMA = 32'h010;
  localparam logic [31:0] CMF  = 32'h8000;
  localparam logic [31:0] OVF  = 32'h4000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_tick = 1'b0;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NCH-1:0] irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cmt_timer #(.NUM_CH(NCH), .CNT_W(CW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk); ref_tick = 1'b1;
      repeat (n) @(negedge clk);
      ref_tick = 1'b0;
    end
  endtask

  // Stop everything, configure channel 0, load its counter through the staging delay.
  task automatic prep0(input logic [31:0] ctrl, input logic [31:0] cmp, input logic [31:0] cnt);
    wr(0, 0);
    wr(4, ctrl);
    wr(6, cmp);
    wr(5, cnt);
    ticks(2);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R2 reset values
    rd(0, d);  check("R2 run", d, 0);
    rd(4, d);  check("R2 ctrl", d, 0);
    rd(5, d);  check("R2 cnt", d, 0);
    rd(6, d);  check("R2 cmp0", d, 32'hFF);
    rd(10, d); check("R2 cmp1", d, 32'hFF);
    check("R2 irq", {30'd0, irq}, 0);

    // R1 unused addresses read zero
    rd(1, d);  check("R1 addr1", d, 0);
    rd(3, d);  check("R1 addr3", d, 0);
    rd(7, d);  check("R1 addr7", d, 0);
    rd(12, d); check("R1 addr12", d, 0);

    // R11 staged counter write
    wr(5, 32'h5A);
    rd(5, d); check("R11 before tick", d, 0);
    ticks(1);
    rd(5, d); check("R11 one tick", d, 0);
    ticks(1);
    rd(5, d); check("R11 two ticks", d, 32'h5A);

    // R3 stopped counter ignores strobes
    ticks(20);
    rd(5, d); check("R3 stopped", d, 32'h5A);

    // R4 R5 divider sweep over every select code
    for (int cs = 0; cs < 8; cs++) begin
      int dv;
      dv = (cs == 7) ? 1 : (cs == 5) ? 32 : (cs == 6) ? 128 : 8;
      prep0(PER | cs, 32'hFF, 0);
      wr(0, 1);
      ticks(5 * dv + dv / 2);
      wr(0, 0);
      rd(5, d); check($sformatf("R4 R5 sel %0d", cs), d, 5);
    end

    // R6 R10 periodic sweep
    for (int c = 0; c < 16; c++) begin
      for (int k = 0; k <= 2 * c + 3; k++) begin
        prep0(PER | IE | RIRQ | 7, c, 0);
        wr(0, 1);
        ticks(k);
        wr(0, 0);
        rd(5, d); check($sformatf("R6 cnt c=%0d k=%0d", c, k), d, k % (c + 1));
        rd(4, d); check($sformatf("R6 flag c=%0d k=%0d", c, k), {31'd0, d[15]}, (k > c) ? 1 : 0);
        check($sformatf("R10 irq c=%0d k=%0d", c, k), {31'd0, irq[0]}, (k > c) ? 1 : 0);
      end
    end

    // R7 free-running mode, then R8 rollover
    prep0(7, 3, 0);
    wr(0, 1); ticks(4); wr(0, 0);
    rd(5, d); check("R7 cnt past cmp", d, 4);
    rd(4, d); check("R7 flags", d & (CMF | OVF), CMF);
    wr(0, 1); ticks(252); wr(0, 0);
    rd(5, d); check("R8 free wrap cnt", d, 0);
    rd(4, d); check("R8 free wrap flags", d & (CMF | OVF), CMF | OVF);

    // R9 write-zero-to-clear
    wr(4, 7 | CMF | OVF);
    rd(4, d); check("R9 write ones", d & (CMF | OVF), CMF | OVF);
    wr(4, 7 | CMF);
    rd(4, d); check("R9 clear ovf only", d & (CMF | OVF), CMF);
    wr(4, 7);
    rd(4, d); check("R9 clear cmf", d & (CMF | OVF), 0);

    // R9 set beats clear in the same cycle
    prep0(PER | 7, 3, 3);
    wr(0, 1);
    @(negedge clk); wr_en = 1'b1; addr = 4; wdata = PER | 7; ref_tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; ref_tick = 1'b0;
    wr(0, 0);
    rd(4, d); check("R9 set wins", d & CMF, CMF);
    rd(5, d); check("R9 set wins cnt", d, 0);

    // R8 periodic overflow when count starts above compare
    prep0(PER | 7, 10, 20);
    wr(0, 1); ticks(235); wr(0, 0);
    rd(5, d); check("R8 at top", d, 32'hFF);
    rd(4, d); check("R8 no flag yet", d & (CMF | OVF), 0);
    wr(0, 1); ticks(1); wr(0, 0);
    rd(5, d); check("R8 rolled", d, 0);
    rd(4, d); check("R8 ovf only", d & (CMF | OVF), OVF);
    wr(0, 1); ticks(11); wr(0, 0);
    rd(5, d); check("R8 then R6 wrap", d, 0);
    rd(4, d); check("R8 then R6 flags", d & (CMF | OVF), CMF | OVF);

    // R10 routing and enable gating
    prep0(PER | IE | RDMA | 7, 2, 0);
    wr(0, 1); ticks(3); wr(0, 0);
    rd(4, d); check("R10 flag set", d & CMF, CMF);
    check("R10 dma route", {31'd0, irq[0]}, 0);
    wr(4, PER | IE | RIRQ | 7 | CMF);
    repeat (2) @(negedge clk);
    check("R10 irq route", {31'd0, irq[0]}, 1);
    wr(4, PER | RIRQ | 7 | CMF);
    repeat (2) @(negedge clk);
    check("R10 disabled", {31'd0, irq[0]}, 0);
    wr(4, PER | IE | RIRQ | 7 | CMF);
    repeat (2) @(negedge clk);
    check("R10 reenabled", {31'd0, irq[0]}, 1);
    wr(4, PER | IE | RIRQ | 7);
    repeat (2) @(negedge clk);
    check("R10 cleared", {31'd0, irq[0]}, 0);

    // R3 per-channel run bits
    prep0(PER | 7, 32'hFF, 0);
    wr(8, PER | 7); wr(9, 0); ticks(2);
    wr(0, 2); ticks(7); wr(0, 0);
    rd(0, d); check("R3 run reg", d, 0);
    rd(5, d); check("R3 ch0 idle", d, 0);
    rd(9, d); check("R3 ch1 ran", d, 7);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule